// File: doc/BRIEF.md
# Min/Max Peak-Detect Decimator

This block sits behind an ADC that always runs at its full sample rate. It reduces the number of stored records by a programmable factor N. It does this without losing narrow spikes. Every valid input sample is examined. Across each window of N valid samples the block keeps a running largest value and a running smallest value. When the sample that closes the window arrives, the block emits one record. That record holds the window's maximum, its minimum and the closing sample itself.

A mode input can turn the record into a plain decimated sample, where all three fields carry the closing sample. The window length is taken once per window, at its first sample. Changing N in the middle of a window therefore does not shorten or stretch that window. Cycles where the valid flag is low do not count toward a window.

Top module: `peak_decim`

## Requirements
- R1: Reset, asynchronous and active low, clears all output fields to zero and drops `out_valid`. The first valid sample after reset opens a fresh window, even if reset arrived partway through a window.
- R2: Exactly one record is emitted per N valid samples. `out_valid` rises in the cycle after the clock edge that accepts the closing sample and lasts one cycle. It is low after every other sample.
- R3: In peak mode (`mode` = 0), `out_max` is the largest sample of the window. Samples are compared as 8-bit two's-complement numbers, so -128 is the smallest and 127 the largest.
- R4: In peak mode, `out_min` is the smallest sample of the window, compared as two's complement.
- R5: The first sample of a window loads both the running maximum and the running minimum directly. Values from earlier windows never appear in a later record.
- R6: The closing sample is counted in the window it closes. The next valid sample opens the following window, and no sample is dropped or shared between windows.
- R7: With N = 1 every valid sample yields a record whose three fields all equal that sample. An N of 0 behaves as N = 1.
- R8: With `mode` = 1 (plain), `out_max`, `out_min` and `out_sample` all carry the closing sample. The mode is read only together with the closing sample.
- R9: `dec_n` is read at the first sample of each window. A change made during a window takes effect at the first sample of the next window.
- R10: A cycle with `in_valid` low changes no window state and produces no record, whatever `in_sample`, `mode` and `dec_n` are.
- R11: `out_sample` carries the closing sample of the window in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample is valid this cycle |
| in_sample | input | 8 | Two's-complement input sample |
| dec_n | input | 16 | Decimation factor N (0 treated as 1) |
| mode | input | 1 | 0 = peak record, 1 = plain decimated record |
| out_valid | output | 1 | One-cycle pulse marking a record |
| out_max | output | 8 | Window maximum (closing sample in plain mode) |
| out_min | output | 8 | Window minimum (closing sample in plain mode) |
| out_sample | output | 8 | Closing sample of the window |

## Verification
The bench sweeps N from 0 to 7 in both modes. The sample sequence visits every 8-bit code, so -128 and 127 both land inside windows. This exposes an unsigned compare, which would report -128 as a maximum.

Successive windows start from unrelated values. A tracker that compared the first sample against leftover extremes would leak the previous window's peak into the record.

The bench also covers three timing cases:
- Changing `dec_n` right after a window opens. A design reading N every cycle would close that window early or late.
- Flipping `mode` on every non-closing sample. This catches a design that latches the mode at the wrong time.
- Idle cycles carrying extreme values. A design that ignored `in_valid` would corrupt the extremes or the count.

A reset partway through a window checks that the count restarts.

// File: rtl/peak_decim_pkg.sv
package peak_decim_pkg;
  typedef enum logic {
    MODE_PEAK  = 1'b0,
    MODE_PLAIN = 1'b1
  } rec_mode_e;
endpackage

// File: rtl/pd_window_ctr.sv
module pd_window_ctr #(
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [NW-1:0] dec_n,
  output logic          first,
  output logic          last
);
  logic [NW-1:0] cnt_q, cnt_d;
  logic [NW-1:0] nlat_q, nlat_d;
  logic [NW-1:0] n_clamp, n_act;

  always_comb begin
    n_clamp = (dec_n == '0) ? NW'(1) : dec_n;
    first   = (cnt_q == '0);
    n_act   = first ? n_clamp : nlat_q;
    last    = ({1'b0, cnt_q} + (NW+1)'(1)) == {1'b0, n_act};
    cnt_d   = cnt_q;
    nlat_d  = nlat_q;
    if (adv) begin
      cnt_d = last ? '0 : cnt_q + NW'(1);
      if (first) nlat_d = n_clamp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      nlat_q <= NW'(1);
    end else begin
      cnt_q  <= cnt_d;
      nlat_q <= nlat_d;
    end
  end

  // R2: an open window never counts past its latched length
  p_cnt_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q < nlat_q));
  // R10: idle cycles leave the window untouched
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(cnt_q) && $stable(nlat_q)));
  // R9: length frozen while a window is open
  p_n_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !first) |=> $stable(nlat_q));
endmodule

// File: rtl/pd_extreme_track.sv
module pd_extreme_track #(
  parameter int W        = 8,
  parameter bit TAKE_MAX = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic                first,
  input  logic signed [W-1:0] sample,
  output logic signed [W-1:0] cand
);
  logic signed [W-1:0] run_q, run_d;
  logic                wins;

  generate
    if (TAKE_MAX) begin : g_max
      always_comb wins = (sample > run_q);
    end else begin : g_min
      always_comb wins = (sample < run_q);
    end
  endgenerate

  always_comb begin
    cand  = (first || wins) ? sample : run_q;
    run_d = adv ? cand : run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  // R10: stored extreme held across idle cycles
  p_run_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(run_q));
endmodule

// File: rtl/peak_decim.sv
module peak_decim
  import peak_decim_pkg::*;
#(
  parameter int W  = 8,
  parameter int NW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_sample,
  input  logic [NW-1:0]       dec_n,
  input  logic                mode,
  output logic                out_valid,
  output logic signed [W-1:0] out_max,
  output logic signed [W-1:0] out_min,
  output logic signed [W-1:0] out_sample
);
  logic                first, last, close;
  logic signed [W-1:0] hi_cand, lo_cand;
  logic                vld_q, vld_d;
  logic signed [W-1:0] max_q, max_d, min_q, min_d, smp_q, smp_d;
  rec_mode_e           mode_e;

  pd_window_ctr #(.NW(NW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .dec_n(dec_n),
    .first(first), .last(last)
  );

  pd_extreme_track #(.W(W), .TAKE_MAX(1'b1)) u_hi (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .first(first),
    .sample(in_sample), .cand(hi_cand)
  );

  pd_extreme_track #(.W(W), .TAKE_MAX(1'b0)) u_lo (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .first(first),
    .sample(in_sample), .cand(lo_cand)
  );

  always_comb begin
    mode_e = rec_mode_e'(mode);
    close  = in_valid && last;
    vld_d  = close;
    max_d  = max_q;
    min_d  = min_q;
    smp_d  = smp_q;
    if (close) begin
      smp_d = in_sample;
      if (mode_e == MODE_PLAIN) begin
        max_d = in_sample;
        min_d = in_sample;
      end else begin
        max_d = hi_cand;
        min_d = lo_cand;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      max_q <= '0;
      min_q <= '0;
      smp_q <= '0;
    end else begin
      vld_q <= vld_d;
      max_q <= max_d;
      min_q <= min_d;
      smp_q <= smp_d;
    end
  end

  assign out_valid  = vld_q;
  assign out_max    = max_q;
  assign out_min    = min_q;
  assign out_sample = smp_q;

  // R3 R4 R11: the closing sample always lies between the reported extremes
  p_record_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_min <= out_sample) && (out_sample <= out_max)));
  // R2: every record comes from an accepted sample
  p_pulse_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  // R8: plain records are flat
  p_plain_flat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode)) |-> ((out_max == out_min) && (out_max == out_sample)));
  // R10: without a record the outputs hold
  p_rec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_max) && $stable(out_min) && $stable(out_sample)));
endmodule

// File: tb/peak_decim_bench.sv
module peak_decim_bench;
  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic signed [7:0] in_sample;
  logic [15:0]       dec_n;
  logic              mode;
  logic              out_valid;
  logic signed [7:0] out_max, out_min, out_sample;

  int total = 0;
  int bad   = 0;
  int kidx  = 0;
  int cycles = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  peak_decim u_peak_decim (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .dec_n(dec_n), .mode(mode), .out_valid(out_valid), .out_max(out_max),
    .out_min(out_min), .out_sample(out_sample)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic signed [7:0] pat(input int k);
    return 8'(k * 73 + 29);
  endfunction

  task automatic send(input logic signed [7:0] v, input logic m);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = v;
    mode      = m;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input logic signed [7:0] v, input logic m);
    @(negedge clk);
    in_valid  = 1'b0;
    in_sample = v;
    mode      = m;
    dec_n     = 16'd3;
    @(posedge clk);
    #1;
  endtask

  task automatic run_window(input int n, input logic m, input int n_after);
    int len;
    logic signed [7:0] v, emax, emin;
    len  = (n == 0) ? 1 : n;
    emax = '0;
    emin = '0;
    for (int j = 0; j < len; j++) begin
      bit lst;
      lst = (j == len - 1);
      v = pat(kidx);
      kidx++;
      if (j == 0) begin emax = v; emin = v; end
      else begin
        if (v > emax) emax = v;
        if (v < emin) emin = v;
      end
      dec_n = 16'(n);
      if (j > 0) dec_n = 16'(n_after);
      send(v, lst ? m : ~m);
      dec_n = 16'(n_after);
      check(out_valid == lst, "R2 R6 pulse", int'(out_valid), int'(lst));
      if (lst) begin
        if (m) begin
          check(out_max == v, "R8 plain max", out_max, v);
          check(out_min == v, "R8 plain min", out_min, v);
        end else if (len == 1) begin
          check(out_max == v && out_min == v, "R7 single", out_max, v);
        end else begin
          check(out_max == emax, "R3 R5 max", out_max, emax);
          check(out_min == emin, "R4 R5 min", out_min, emin);
        end
        check(out_sample == v, "R11 closing sample", out_sample, v);
      end else if (j % 3 == 1) begin
        idle((j % 2 == 0) ? 8'sh7f : -8'sd128, ~m);
        check(!out_valid, "R10 idle no record", int'(out_valid), 0);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; dec_n = 16'd1; mode = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(!out_valid && out_max == 0 && out_min == 0 && out_sample == 0,
          "R1 reset state", int'(out_valid), 0);
    @(negedge clk); rst_n = 1'b1;

    // partial window then reset: count restarts (R1)
    dec_n = 16'd4;
    send(8'sd5, 1'b0);
    send(8'sd9, 1'b0);
    @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
    #1;
    check(!out_valid, "R1 reset mid window", int'(out_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    run_window(4, 1'b0, 4);

    // sweep of N and mode (R2 R3 R4 R5 R6 R8 R11)
    for (int n = 0; n <= 7; n++)
      for (int m = 0; m < 2; m++)
        for (int r = 0; r < 6; r++)
          run_window(n, m[0], n);

    // N=1 across every code (R7)
    for (int i = 0; i < 256; i++) run_window(1, 1'b0, 1);

    // N change inside a window takes effect next window (R9)
    run_window(4, 1'b0, 2);
    run_window(2, 1'b0, 5);
    run_window(5, 1'b0, 3);
    run_window(3, 1'b1, 7);
    run_window(7, 1'b0, 7);

    // long peak run covering extremes (R3 R4)
    for (int r = 0; r < 60; r++) run_window(5, 1'b0, 5);

    idle(8'sh7f, 1'b1);
    check(!out_valid, "R2 single pulse", int'(out_valid), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule